// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM in which read and write operations can follow each other on every clock cycle, in any mix, with no idle bus cycle between them. The address and all controls are sampled on the rising clock edge. A read returns its word two enabled edges after its address through a registered output stage. A write supplies its data two enabled edges after its address. This alignment puts read data and write data in the same bus slot, so a change of direction never costs a cycle.

A write stays in a short address/control pipeline until its data arrives. A read of a word whose write is still in flight is served from that pending data, merged byte by byte. An advance input continues a four-beat burst from an internal address counter, in linear or interleaved order. A clock enable freezes the whole block. Three chip selects, an asynchronous output enable and a sleep input gate access. The depth is a parameter that is kept small for simulation. The word holds BYTES lanes of BYTE_W bits each: the default is four 9-bit lanes, and two lanes gives the narrow mode.

Top module: `pipe_sram`

## Requirements
- R1: After a synchronous reset, dout_valid is 0 and dout is all zeros until a read completes.
- R2: A read sampled at enabled edge k (adv=0, selected, wr=0) shows the word at addr on dout, with dout_valid=1, after enabled edge k+2. Its slot holds until the next enabled edge.
- R3: A write sampled at enabled edge k takes its data from din at enabled edge k+2. Lane b is bits [b*BYTE_W +: BYTE_W] and is written only where byte_en[b]=1; the other lanes keep their contents.
- R4: A read issued on the cycle right after a write to the same address returns the new data in the written lanes and the old data in the others, with no stall.
- R5: While clk_en=0, edges are ignored: no operation starts, no write lands, and dout and dout_valid hold.
- R6: The device is selected only when sel_a=1, sel_b_n=0 and sel_c=1. Otherwise a load cycle is a deselect: its slot shows dout_valid=0 and memory is unchanged.
- R7: oe=0 forces dout to zero and dout_valid to 0 at once, without waiting for a clock edge, and does not disturb the pipeline.
- R8: sleep=1 forces dout and dout_valid low at once. Any operation sampled while sleep=1 is treated as a deselect.
- R9: adv=1 continues the last loaded operation (read or write) at the next burst address. The chip selects and wr are ignored on such a cycle, and byte_en is taken fresh on each beat.
- R10: Beat n of a burst (n = 1, 2, 3, 0, … counted from the load) keeps the upper address bits. Its low two bits are base+n mod 4 when linear_order=1, and base XOR n when linear_order=0.
- R11: adv=1 after a deselect or a sleep cycle is also a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; low suspends the block |
| sel_a | input | 1 | Chip select, active high |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| wr | input | 1 | 1 = write, 0 = read (load cycles only) |
| byte_en | input | BYTES | Per-lane write enables |
| adv | input | 1 | 1 = burst continuation, 0 = new address load |
| addr | input | ADDR_W | Word address |
| din | input | BYTES*BYTE_W | Write data, two enabled edges after its address |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Power-down; blocks new operations and the outputs |
| linear_order | input | 1 | Burst order: 1 linear, 0 interleaved; keep static |
| dout | output | BYTES*BYTE_W | Read data, zero when not valid |
| dout_valid | output | 1 | Read slot driven |

## Verification
On every cycle the assertions check four things. Deselect, sleep and continuation cycles enter the pipeline as the right operation kind. A read in the last pipeline stage always produces a valid output slot. A suspend freezes the output register. Burst beats never repeat the base address within a wrap. Only the bench scenarios can show that the data is right. That covers the two-slot alignment of read and write data, the per-lane bypass merge on back-to-back write and read, the address sequence of each burst order, and the immediate effect of oe and sleep in the middle of a cycle. The bench compares against its own memory model under random mixes of these cases.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_kind_t;

  localparam int BURST_W = 2;
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              load,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nx, lo;

  always_comb begin
    cnt_nx = cnt_q + 1'b1;
    lo     = linear ? (base_q[BURST_W-1:0] + cnt_nx) : (base_q[BURST_W-1:0] ^ cnt_nx);
    addr_out = load ? addr_in : {base_q[ADDR_W-1:BURST_W], lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (ce) begin
      if (load) begin
        base_q <= addr_in;
        cnt_q  <= '0;
      end else if (step) begin
        cnt_q <= cnt_nx;
      end
    end
  end

  // R10: beats 1..3 of a wrap never revisit the base word
  assert_burst_distinct_R10: assert property (@(posedge clk) disable iff (rst)
    (ce && !load && step && cnt_q != 2'd3) |-> (addr_out != base_q));
endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    ce,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [BYTES*BYTE_W-1:0] rdata,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [BYTES-1:0]        wbe,
  input  logic [BYTES*BYTE_W-1:0] wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (ce) begin
        rdata[b*BYTE_W +: BYTE_W] <= mem[raddr];
        if (wbe[b]) mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic [BYTES-1:0]        cap_be,
  input  logic [BYTES*BYTE_W-1:0] cap_data,
  input  logic [BYTES*BYTE_W-1:0] rd_data,
  input  logic                    slot_read,
  output logic [BYTES*BYTE_W-1:0] data_q,
  output logic                    valid_q
);
  localparam int DATA_W = BYTES * BYTE_W;

  logic [BYTES-1:0]  byp_be_q;
  logic [DATA_W-1:0] byp_d_q, merged;

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign merged[b*BYTE_W +: BYTE_W] = byp_be_q[b] ? byp_d_q[b*BYTE_W +: BYTE_W]
                                                    : rd_data[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_be_q <= '0;
      byp_d_q  <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
    end else if (ce) begin
      byp_be_q <= cap_be;
      byp_d_q  <= cap_data;
      data_q   <= slot_read ? merged : '0;
      valid_q  <= slot_read;
    end
  end

  // R2: a read reaching this stage always yields a valid slot
  assert_read_slot_R2: assert property (@(posedge clk) disable iff (rst)
    (ce && slot_read) |=> valid_q);
  // R5: suspended edges leave the output register untouched
  assert_suspend_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(data_q) && $stable(valid_q)));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en,
  input  logic                    sel_a,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic                    wr,
  input  logic [BYTES-1:0]        byte_en,
  input  logic                    adv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] din,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic                    linear_order,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dout_valid
);
  localparam int DATA_W = BYTES * BYTE_W;

  op_kind_t          cur_kind_q, new_kind, s1_kind, s2_kind;
  logic [ADDR_W-1:0] op_addr, s1_addr, s2_addr;
  logic [BYTES-1:0]  s1_be, s2_be, ram_wbe, cap_be;
  logic              selected, do_load, do_step;
  logic [DATA_W-1:0] rd_data, data_q;
  logic              valid_q;

  assign selected = sel_a & ~sel_b_n & sel_c;

  always_comb begin
    new_kind = OP_IDLE;
    do_load  = 1'b0;
    do_step  = 1'b0;
    if (!sleep) begin
      if (!adv) begin
        do_load  = 1'b1;
        new_kind = selected ? (wr ? OP_WRITE : OP_READ) : OP_IDLE;
      end else begin
        new_kind = cur_kind_q;
        do_step  = (cur_kind_q != OP_IDLE);
      end
    end
  end

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst(rst), .ce(clk_en), .load(do_load), .step(do_step),
    .linear(linear_order), .addr_in(addr), .addr_out(op_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_kind_q <= OP_IDLE;
      s1_kind    <= OP_IDLE;
      s2_kind    <= OP_IDLE;
      s1_addr    <= '0;
      s2_addr    <= '0;
      s1_be      <= '0;
      s2_be      <= '0;
    end else if (clk_en) begin
      if (sleep)        cur_kind_q <= OP_IDLE;
      else if (do_load) cur_kind_q <= new_kind;
      s1_kind <= new_kind;
      s1_addr <= op_addr;
      s1_be   <= byte_en;
      s2_kind <= s1_kind;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  assign ram_wbe = (s2_kind == OP_WRITE) ? s2_be : '0;
  assign cap_be  = (s2_kind == OP_WRITE && s2_addr == s1_addr) ? s2_be : '0;

  byte_ram #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_ram (
    .clk(clk), .ce(clk_en), .raddr(s1_addr), .rdata(rd_data),
    .waddr(s2_addr), .wbe(ram_wbe), .wdata(din)
  );

  out_stage #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst(rst), .ce(clk_en), .cap_be(cap_be), .cap_data(din),
    .rd_data(rd_data), .slot_read(s2_kind == OP_READ),
    .data_q(data_q), .valid_q(valid_q)
  );

  assign dout_valid = oe & ~sleep & valid_q;
  assign dout       = dout_valid ? data_q : '0;

  // R6: an unselected load cycle enters the pipeline as idle
  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !adv && !selected) |=> (s1_kind == OP_IDLE));
  // R8: nothing is accepted while asleep
  assert_sleep_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sleep) |=> (s1_kind == OP_IDLE));
  // R9: a continuation repeats the kind of the last load
  assert_cont_kind_R9: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv && !sleep) |=> (s1_kind == $past(cur_kind_q)));
endmodule

// File: tb/tb_pipe_sram.sv
`timescale 1ns/1ps
module tb_pipe_sram;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1, clk_en = 0, sel_a = 0, sel_b_n = 1, sel_c = 0, wr = 0;
  logic [NB-1:0] byte_en = '0;
  logic adv = 0, oe = 1, sleep = 0, linear_order = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic dout_valid;

  int checks = 0, errors = 0;
  bit armed = 0, done = 0;

  pipe_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sel_a(sel_a), .sel_b_n(sel_b_n),
    .sel_c(sel_c), .wr(wr), .byte_en(byte_en), .adv(adv), .addr(addr),
    .din(din), .oe(oe), .sleep(sleep), .linear_order(linear_order),
    .dout(dout), .dout_valid(dout_valid)
  );

  always #10 clk = ~clk;

  // reference model: kinds 0 idle, 1 read, 2 write
  logic [DW-1:0] ref_mem [DEPTH];
  int ck, h1k, h2k, nk;
  logic [AW-1:0] base, h1a, h2a, na;
  logic [NB-1:0] h1be, h2be;
  logic [1:0] bcnt, lo;
  logic exp_v;
  logic [DW-1:0] exp_d;

  always @(posedge clk) begin
    if (rst) begin
      ck = 0; h1k = 0; h2k = 0; exp_v = 0; exp_d = '0; bcnt = '0; base = '0;
    end else if (clk_en) begin
      nk = 0; na = addr;
      if (sleep) ck = 0;
      else if (!adv) begin
        nk = (sel_a && !sel_b_n && sel_c) ? (wr ? 2 : 1) : 0;
        base = addr; bcnt = '0; ck = nk;
      end else if (ck != 0) begin
        bcnt = bcnt + 2'd1;
        lo = linear_order ? (base[1:0] + bcnt) : (base[1:0] ^ bcnt);
        na = {base[AW-1:2], lo};
        nk = ck;
      end
      if (h2k == 2)
        for (int b = 0; b < NB; b++)
          if (h2be[b]) ref_mem[h2a][b*BW +: BW] = din[b*BW +: BW];
      exp_v = (h2k == 1);
      exp_d = exp_v ? ref_mem[h2a] : '0;
      h2k = h1k; h2a = h1a; h2be = h1be;
      h1k = nk;  h1a = na;  h1be = byte_en;
    end
  end

  task automatic check(input string tag);
    logic ev;
    logic [DW-1:0] ed;
    ev = exp_v && oe && !sleep;
    ed = ev ? exp_d : '0;
    checks++;
    if (dout_valid !== ev || dout !== ed) begin
      errors++;
      $display("FAIL %s: dout_valid=%0b dout=%h expected dout_valid=%0b dout=%h",
               tag, dout_valid, dout, ev, ed);
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    if (armed) check(tag);
    din = {$urandom, $urandom};
  endtask

  task automatic set_sel(input bit on);
    sel_a = on; sel_b_n = !on; sel_c = on;
  endtask

  task automatic op_rd(input string tag, input logic [AW-1:0] a);
    tick(tag); clk_en = 1; set_sel(1); wr = 0; adv = 0; addr = a;
  endtask

  task automatic op_wr(input string tag, input logic [AW-1:0] a, input logic [NB-1:0] be);
    tick(tag); clk_en = 1; set_sel(1); wr = 1; adv = 0; addr = a; byte_en = be;
  endtask

  task automatic op_cont(input string tag, input logic [NB-1:0] be);
    tick(tag); clk_en = 1; adv = 1; byte_en = be; set_sel(0); wr = 0;
  endtask

  task automatic op_nop(input string tag);
    tick(tag); clk_en = 1; set_sel(0); wr = 1; adv = 0; addr = AW'($urandom);
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 3; i++) op_nop(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; clk_en = 1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (dout_valid !== 1'b0 || dout !== '0) begin
      errors++;
      $display("FAIL R1: dout_valid=%0b dout=%h expected 0 and 0", dout_valid, dout);
    end
    armed = 1;
    // fill every word (R3 full-lane writes)
    for (int a = 0; a < DEPTH; a++) op_wr("R3", AW'(a), '1);
    flush("R3");
    // R2: plain reads, back to back
    for (int a = 0; a < 8; a++) op_rd("R2", AW'(a * 5));
    flush("R2");
    // R3: partial lanes, read later
    op_wr("R3", 6'd12, 4'b1010); op_nop("R3"); op_nop("R3"); op_rd("R3", 6'd12); flush("R3");
    // R4: write immediately followed by a read of the same word, alternating
    op_wr("R4", 6'd9, 4'b0101); op_rd("R4", 6'd9);
    op_wr("R4", 6'd9, 4'b0010); op_rd("R4", 6'd9); op_rd("R4", 6'd9);
    op_wr("R4", 6'd3, 4'b1111); op_wr("R4", 6'd4, 4'b1001); op_rd("R4", 6'd4); op_rd("R4", 6'd3);
    flush("R4");
    // R5: suspend in the middle of the pipeline
    op_wr("R5", 6'd20, 4'b1100); op_rd("R5", 6'd20);
    tick("R5"); clk_en = 0; set_sel(1); wr = 1; addr = 6'd21; byte_en = '1;
    tick("R5"); tick("R5"); tick("R5");
    clk_en = 1; set_sel(0);
    op_rd("R5", 6'd21); flush("R5");
    // R6: each select off in turn with wr=1, then read the word back
    op_wr("R6", 6'd30, '1); flush("R6");
    tick("R6"); set_sel(1); sel_a = 0; wr = 1; adv = 0; addr = 6'd30; byte_en = '1;
    tick("R6"); set_sel(1); sel_b_n = 1; wr = 1; addr = 6'd30;
    tick("R6"); set_sel(1); sel_c = 0; wr = 1; addr = 6'd30;
    op_rd("R6", 6'd30); op_rd("R6", 6'd30); flush("R6");
    // R7: oe low for whole cycles and toggled mid-cycle
    op_rd("R7", 6'd7); op_rd("R7", 6'd8);
    tick("R7"); oe = 0; set_sel(0);
    tick("R7"); tick("R7"); oe = 1;
    op_rd("R7", 6'd10); op_nop("R7"); op_nop("R7");
    @(negedge clk); #2 oe = 0; #1 check("R7"); oe = 1; #1 check("R7");
    flush("R7");
    // R8: sleep blocks ops and outputs
    op_rd("R8", 6'd11); op_nop("R8");
    tick("R8"); sleep = 1; set_sel(1); wr = 0; addr = 6'd12;
    tick("R8"); sleep = 0;
    op_nop("R8"); op_nop("R8");
    @(negedge clk); #2 sleep = 1; #1 check("R8"); sleep = 0; #1 check("R8");
    flush("R8");
    // R9/R10: linear write burst then interleaved read burst
    linear_order = 1;
    op_wr("R9", 6'd22, '1); op_cont("R9", 4'b0110); op_cont("R9", '1); op_cont("R10", 4'b0001);
    op_cont("R10", '1); flush("R10");
    for (int i = 0; i < 4; i++) op_rd("R10", AW'(20 + i));
    flush("R10");
    linear_order = 0;
    op_rd("R10", 6'd22); op_cont("R10", '0); op_cont("R10", '0); op_cont("R10", '0); op_cont("R10", '0);
    flush("R10");
    // R11: continuation after deselect and after sleep
    op_nop("R11"); op_cont("R11", '1); op_cont("R11", '1);
    op_rd("R11", 6'd5);
    tick("R11"); sleep = 1; adv = 0;
    tick("R11"); sleep = 0; adv = 1;
    op_cont("R11", '1); flush("R11");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      tick("R2");
      if (i % 500 == 0) linear_order = $urandom_range(0, 1);
      clk_en  = ($urandom_range(0, 9) != 0);
      set_sel($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 15) == 0) sel_b_n = 1;
      wr      = $urandom_range(0, 1);
      byte_en = NB'($urandom);
      adv     = ($urandom_range(0, 3) == 0);
      addr    = AW'($urandom);
      oe      = ($urandom_range(0, 9) != 0);
      sleep   = ($urandom_range(0, 31) == 0);
    end
    oe = 1; sleep = 0;
    flush("R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule